// File: doc/BRIEF.md
# Overlay Auxiliary Pin Controller

This block drives the side pins of an on-screen overlay engine that runs on the dot clock. The first pin is shared between two jobs. With the PWM clock enable low it is a halftone flag: it is high over a background window except where a glyph pixel is drawn, so the video amplifiers outside the chip can dim the picture behind the window. With the enable high the same pin carries a clock for an external pulse-width modulator. That clock is the dot clock divided by ten, five cycles high and five low. Every falling edge of the active-low horizontal sync restarts it on a high half. In each line it gives 32 periods in the low-resolution mode and 48 in the high-resolution mode, then rests low until the next sync edge.

The second pin is a fast-blanking flag. A frame control bit picks its meaning: either "glyph or window is shown" or "glyph is shown". The fast-blanking pin is undriven whenever there is nothing to show. The colour pins are undriven while the overlay is off. Each undriven state appears as a low output-enable next to the data pin, and the pad ring builds the tri-state buffer. Every pin comes from a register, so changing a control bit cannot produce a glitch.

Internally, a synchronizer with an edge detector finds the line start. A four-state divider machine produces the clock: PWM_IDLE, PWM_HIGH, PWM_LOW and PWM_PARK. The transitions are LINE_START (any state to PWM_HIGH), HALF_DONE (PWM_HIGH to PWM_LOW), NEXT_PERIOD (PWM_LOW to PWM_HIGH) and LINE_DONE (PWM_LOW to PWM_PARK once the period budget is used up). An output register stage then selects what each pin carries.

Top module: `ovl_pin_ctrl`

## Requirements
- R1: With `pwm_en` = 0, `aux_pin` equals `osd_en & win_active & ~char_active`, delayed by one clock.
- R2: With `pwm_en` = 1, `aux_pin` alternates between runs of exactly 5 clocks high and 5 clocks low.
- R3: Each line gives 32 high pulses when `mode_hi` = 0 and 48 when `mode_hi` = 1. After that `aux_pin` stays low until the next line start.
- R4: A falling edge on `hsync_n` restarts the clock on a high half, even in the middle of a period. Call E the first rising clock edge that samples `hsync_n` low. `aux_pin` is still low after E+2 (when it was low before) and is high after E+3.
- R5: `mode_hi` is sampled only at a line start. A change in the middle of a line takes effect on the next line.
- R6: After reset and before the first falling edge of `hsync_n`, `aux_pin` stays low in clock mode.
- R7: With `fb_chars_only` = 0, `fb_pin` is driven high (`fb_oe` = 1) when a glyph or window pixel is active. With `fb_chars_only` = 1, it is driven high on glyph pixels and driven low on window pixels without a glyph. All of this has one clock of latency.
- R8: `fb_oe` is 0 one clock after `osd_en` = 0, or after neither glyph nor window is active.
- R9: `rgb_oe` follows `osd_en` with one clock of delay. `rgb_pin` is the registered `rgb_in` while enabled and 0 otherwise.
- R10: During reset, `aux_pin`, `fb_oe` and `rgb_oe` are 0.
- R11: A change of `pwm_en` reaches `aux_pin` on the next clock edge, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| mode_hi | input | 1 | 1 = high-resolution mode (48 periods per line), 0 = 32 |
| pwm_en | input | 1 | 1 = shared pin carries the PWM clock, 0 = halftone flag |
| fb_chars_only | input | 1 | Fast-blanking meaning: 1 = glyphs only, 0 = glyphs or windows |
| osd_en | input | 1 | Overlay display enable |
| win_active | input | 1 | Current pixel lies in a background window |
| char_active | input | 1 | Current pixel is a glyph dot |
| rgb_in | input | RGB_W | Colour of the current pixel |
| aux_pin | output | 1 | Shared halftone / PWM clock pin |
| fb_pin | output | 1 | Fast-blanking data |
| fb_oe | output | 1 | Fast-blanking output enable (0 = high impedance) |
| rgb_pin | output | RGB_W | Colour pin data |
| rgb_oe | output | 1 | Colour pin output enable (0 = high impedance) |

## Verification
The hardest case to reach from the ports is a sync edge that arrives in the middle of a period. The restart has to cut a low half short and begin a fresh high half with no extra-long pulse. The stimulus starts a line and counts the output samples until the first low sample appears, then drops `hsync_n` at once. This places the edge a known distance into the low half, so the shortened low run and the exact clock edge of the new high half can both be predicted. A change of `mode_hi` in the middle of a line, made after the period budget has been latched, checks that the count follows the mode seen at the line start.

// File: rtl/ovl_pin_pkg.sv
package ovl_pin_pkg;

    typedef enum logic [1:0] {
        PWM_IDLE = 2'd0,
        PWM_HIGH = 2'd1,
        PWM_LOW  = 2'd2,
        PWM_PARK = 2'd3
    } pwm_state_e;

endpackage

// File: rtl/ovl_sync_edge.sv
module ovl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    // Chain of STAGES synchronizer flops plus one history flop.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], sig_n};
        end
    end

    // A high-to-low step between the two oldest samples marks a line start.
    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/ovl_pwm_div.sv
module ovl_pwm_div
    import ovl_pin_pkg::*;
#(
    parameter int HALF   = 5,
    parameter int PER_LO = 32,
    parameter int PER_HI = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       mode_hi,
    output logic       pwm_hi,
    output pwm_state_e state
);
    localparam int PER_MAX = (PER_HI > PER_LO) ? PER_HI : PER_LO;
    localparam int PH_W    = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int PER_W   = $clog2(PER_MAX + 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(HALF - 1);

    pwm_state_e       state_q, state_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic [PER_W-1:0] per_q, per_d;
    logic [PER_W-1:0] lim_q, lim_d;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWM_IDLE;
            ph_q    <= '0;
            per_q   <= '0;
            lim_q   <= PER_W'(PER_LO);
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            per_q   <= per_d;
            lim_q   <= lim_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        per_d   = per_q;
        lim_d   = lim_q;
        if (line_start) begin
            // LINE_START: restart on a high half, latch the period budget.
            state_d = PWM_HIGH;
            ph_d    = '0;
            per_d   = '0;
            lim_d   = mode_hi ? PER_W'(PER_HI) : PER_W'(PER_LO);
        end else begin
            unique case (state_q)
                PWM_IDLE: begin
                    state_d = PWM_IDLE;
                end
                PWM_HIGH: begin
                    if (ph_q == PH_LAST) begin
                        // HALF_DONE
                        state_d = PWM_LOW;
                        ph_d    = '0;
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                PWM_LOW: begin
                    if (ph_q == PH_LAST) begin
                        ph_d = '0;
                        if (per_q == lim_q - PER_W'(1)) begin
                            // LINE_DONE
                            state_d = PWM_PARK;
                        end else begin
                            // NEXT_PERIOD
                            state_d = PWM_HIGH;
                            per_d   = per_q + 1'b1;
                        end
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                PWM_PARK: begin
                    state_d = PWM_PARK;
                end
                default: begin
                    state_d = PWM_IDLE;
                end
            endcase
        end
    end

    assign pwm_hi = (state_q == PWM_HIGH);
    assign state  = state_q;

endmodule

// File: rtl/ovl_pin_mux.sv
module ovl_pin_mux #(
    parameter int RGB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_en,
    input  logic             pwm_hi,
    input  logic             osd_en,
    input  logic             win_active,
    input  logic             char_active,
    input  logic             fb_chars_only,
    input  logic [RGB_W-1:0] rgb_in,
    output logic             aux_q,
    output logic             fb_q,
    output logic             fb_oe_q,
    output logic [RGB_W-1:0] rgb_q,
    output logic             rgb_oe_q
);
    logic shown;
    logic halftone;
    logic fb_level;

    always_comb begin
        shown    = osd_en & (win_active | char_active);
        halftone = osd_en & win_active & ~char_active;
        fb_level = fb_chars_only ? char_active : 1'b1;
    end

    // Output register process: every pin leaves a flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q    <= 1'b0;
            fb_q     <= 1'b0;
            fb_oe_q  <= 1'b0;
            rgb_q    <= '0;
            rgb_oe_q <= 1'b0;
        end else begin
            aux_q    <= pwm_en ? pwm_hi : halftone;
            fb_oe_q  <= shown;
            fb_q     <= shown & fb_level;
            rgb_oe_q <= osd_en;
            rgb_q    <= osd_en ? rgb_in : '0;
        end
    end

endmodule

// File: rtl/ovl_pin_ctrl.sv
module ovl_pin_ctrl
    import ovl_pin_pkg::*;
#(
    parameter int DIV         = 10,
    parameter int LINE_PER_LO = 32,
    parameter int LINE_PER_HI = 48,
    parameter int SYNC_STAGES = 2,
    parameter int RGB_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_n,
    input  logic             mode_hi,
    input  logic             pwm_en,
    input  logic             fb_chars_only,
    input  logic             osd_en,
    input  logic             win_active,
    input  logic             char_active,
    input  logic [RGB_W-1:0] rgb_in,
    output logic             aux_pin,
    output logic             fb_pin,
    output logic             fb_oe,
    output logic [RGB_W-1:0] rgb_pin,
    output logic             rgb_oe
);
    localparam int HALF = DIV / 2;

    logic       line_start;
    logic       pwm_hi;
    pwm_state_e pwm_state;

    ovl_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .sig_n(hsync_n),
        .fall (line_start)
    );

    ovl_pwm_div #(
        .HALF  (HALF),
        .PER_LO(LINE_PER_LO),
        .PER_HI(LINE_PER_HI)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .mode_hi   (mode_hi),
        .pwm_hi    (pwm_hi),
        .state     (pwm_state)
    );

    ovl_pin_mux #(
        .RGB_W(RGB_W)
    ) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_en       (pwm_en),
        .pwm_hi       (pwm_hi),
        .osd_en       (osd_en),
        .win_active   (win_active),
        .char_active  (char_active),
        .fb_chars_only(fb_chars_only),
        .rgb_in       (rgb_in),
        .aux_q        (aux_pin),
        .fb_q         (fb_pin),
        .fb_oe_q      (fb_oe),
        .rgb_q        (rgb_pin),
        .rgb_oe_q     (rgb_oe)
    );

endmodule

// File: rtl/ovl_pin_chk.sv
module ovl_pin_chk #(
    parameter int DIV     = 10,
    parameter int PER_MAX = 48
) (
    input logic clk,
    input logic rst_n,
    input logic line_start,
    input logic pwm_hi,
    input logic pwm_en,
    input logic osd_en,
    input logic win_active,
    input logic char_active,
    input logic fb_chars_only,
    input logic aux_pin,
    input logic fb_pin,
    input logic fb_oe,
    input logic rgb_oe
);
    localparam int HALF = DIV / 2;

    logic [7:0] hi_run;
    logic [7:0] rises;
    logic       pwm_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run   <= '0;
            rises    <= '0;
            pwm_prev <= 1'b0;
        end else begin
            pwm_prev <= pwm_hi;
            if (line_start) begin
                hi_run <= '0;
                rises  <= '0;
            end else begin
                hi_run <= pwm_hi ? hi_run + 8'd1 : 8'd0;
                if (pwm_hi && !pwm_prev) begin
                    rises <= rises + 8'd1;
                end
            end
        end
    end

    // R2: no high half lasts longer than DIV/2 clocks
    a_r2_high_run: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_hi |-> (hi_run < 8'(HALF)));

    // R3: the period count in a line never exceeds the larger budget
    a_r3_period_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rises <= 8'(PER_MAX));

    // R4: a line start always opens a high half
    a_r4_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> pwm_hi);

    // R1: a glyph pixel blanks the halftone flag
    a_r1_glyph_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && char_active) |=> !aux_pin);

    // R7: glyphs-only mode drives low over a bare window
    a_r7_window_low: assert property (@(posedge clk) disable iff (!rst_n)
        (osd_en && fb_chars_only && win_active && !char_active) |=> (fb_oe && !fb_pin));

    // R8: overlay off releases fast blanking
    a_r8_fb_release: assert property (@(posedge clk) disable iff (!rst_n)
        !osd_en |=> !fb_oe);

    // R9: overlay off releases the colour pins
    a_r9_rgb_release: assert property (@(posedge clk) disable iff (!rst_n)
        !osd_en |=> !rgb_oe);

endmodule

bind ovl_pin_ctrl ovl_pin_chk #(
    .DIV    (DIV),
    .PER_MAX(LINE_PER_HI)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start   (line_start),
    .pwm_hi       (pwm_hi),
    .pwm_en       (pwm_en),
    .osd_en       (osd_en),
    .win_active   (win_active),
    .char_active  (char_active),
    .fb_chars_only(fb_chars_only),
    .aux_pin      (aux_pin),
    .fb_pin       (fb_pin),
    .fb_oe        (fb_oe),
    .rgb_oe       (rgb_oe)
);

// File: tb/tb_ovl_pin_ctrl.sv
module tb_ovl_pin_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_n = 1'b1;
    logic       mode_hi = 1'b0;
    logic       pwm_en = 1'b0;
    logic       fb_chars_only = 1'b0;
    logic       osd_en = 1'b0;
    logic       win_active = 1'b0;
    logic       char_active = 1'b0;
    logic [2:0] rgb_in = 3'd0;
    logic       aux_pin, fb_pin, fb_oe, rgb_oe;
    logic [2:0] rgb_pin;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    ovl_pin_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .mode_hi(mode_hi),
        .pwm_en(pwm_en), .fb_chars_only(fb_chars_only), .osd_en(osd_en),
        .win_active(win_active), .char_active(char_active), .rgb_in(rgb_in),
        .aux_pin(aux_pin), .fb_pin(fb_pin), .fb_oe(fb_oe),
        .rgb_pin(rgb_pin), .rgb_oe(rgb_oe)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start a line and verify the restart latency (R4), then measure it.
    task automatic run_line(input string req, input int exp_per, input bit flip_mode);
        int level;
        int run;
        int rises;
        int bad;
        hsync_n = 1'b0;
        step(); step(); step();
        chk("R4 still low after E+2", aux_pin, 0);
        hsync_n = 1'b1;
        step();
        chk("R4 high after E+3", aux_pin, 1);
        level = 1; run = 1; rises = 1; bad = 0;
        for (int i = 0; i < 600; i++) begin
            if (flip_mode && i == 20) mode_hi = ~mode_hi;
            step();
            if (aux_pin == level) begin
                run++;
            end else begin
                if (run != 5) bad++;
                if (aux_pin) rises++;
                level = aux_pin;
                run = 1;
            end
        end
        chk({req, " R2 run lengths"}, bad, 0);
        chk({req, " pulse count"}, rises, exp_per);
        chk({req, " parked low"}, level, 0);
    endtask

    task automatic t_reset();
        chk("R10 aux in reset", aux_pin, 0);
        chk("R10 fb_oe in reset", fb_oe, 0);
        chk("R10 rgb_oe in reset", rgb_oe, 0);
    endtask

    task automatic t_idle_before_sync();
        pwm_en = 1'b1;
        osd_en = 1'b1;
        win_active = 1'b1;
        for (int i = 0; i < 10; i++) step();
        chk("R6 idle before first sync", aux_pin, 0);
        win_active = 1'b0;
    endtask

    task automatic t_lines();
        mode_hi = 1'b0;
        run_line("R3 mode 0", 32, 1'b0);
        mode_hi = 1'b1;
        run_line("R3 mode 1", 48, 1'b0);
        mode_hi = 1'b0;
        run_line("R5 flip to 1 mid-line", 32, 1'b1);
        run_line("R5 next line in mode 1", 48, 1'b0);
        mode_hi = 1'b0;
    endtask

    task automatic t_realign();
        int cnt;
        hsync_n = 1'b0;
        step(); step(); step();
        hsync_n = 1'b1;
        step();
        // First high sample seen; wait for the first low sample.
        for (int i = 0; i < 4; i++) step();
        chk("R2 last high sample", aux_pin, 1);
        step();
        chk("R2 first low sample", aux_pin, 0);
        hsync_n = 1'b0;
        step(); step(); step();
        chk("R4 mid-period still low", aux_pin, 0);
        hsync_n = 1'b1;
        step();
        chk("R4 mid-period restart high", aux_pin, 1);
        cnt = 1;
        for (int i = 0; i < 4; i++) begin
            step();
            if (aux_pin) cnt++;
        end
        step();
        chk("R4 restarted high half length", cnt, 5);
        chk("R4 low after restarted half", aux_pin, 0);
        for (int i = 0; i < 600; i++) step();
    endtask

    task automatic t_enable_switch();
        win_active = 1'b0;
        hsync_n = 1'b0;
        step(); step(); step();
        hsync_n = 1'b1;
        step();
        chk("R11 clock high before switch", aux_pin, 1);
        pwm_en = 1'b0;
        step();
        chk("R11 halftone takes over", aux_pin, 0);
        pwm_en = 1'b1;
        step();
        chk("R11 clock resumes", aux_pin, 1);
        for (int i = 0; i < 600; i++) step();
    endtask

    task automatic t_halftone();
        pwm_en = 1'b0;
        osd_en = 1'b1;
        win_active = 1'b1; char_active = 1'b0; step();
        chk("R1 window only", aux_pin, 1);
        win_active = 1'b1; char_active = 1'b1; step();
        chk("R1 window with glyph", aux_pin, 0);
        win_active = 1'b0; char_active = 1'b1; step();
        chk("R1 glyph only", aux_pin, 0);
        win_active = 1'b0; char_active = 1'b0; step();
        chk("R1 nothing", aux_pin, 0);
        osd_en = 1'b0; win_active = 1'b1; step();
        chk("R1 overlay off", aux_pin, 0);
        osd_en = 1'b1; win_active = 1'b0;
    endtask

    task automatic t_fast_blank();
        osd_en = 1'b1;
        fb_chars_only = 1'b0;
        win_active = 1'b1; char_active = 1'b0; step();
        chk("R7 any: window oe", fb_oe, 1);
        chk("R7 any: window level", fb_pin, 1);
        win_active = 1'b0; char_active = 1'b1; step();
        chk("R7 any: glyph level", fb_pin, 1);
        win_active = 1'b0; char_active = 1'b0; step();
        chk("R8 nothing shown", fb_oe, 0);
        fb_chars_only = 1'b1;
        win_active = 1'b0; char_active = 1'b1; step();
        chk("R7 glyphs: glyph oe", fb_oe, 1);
        chk("R7 glyphs: glyph level", fb_pin, 1);
        win_active = 1'b1; char_active = 1'b0; step();
        chk("R7 glyphs: window oe", fb_oe, 1);
        chk("R7 glyphs: window level", fb_pin, 0);
        osd_en = 1'b0; char_active = 1'b1; step();
        chk("R8 overlay off", fb_oe, 0);
        win_active = 1'b0; char_active = 1'b0;
    endtask

    task automatic t_rgb();
        osd_en = 1'b1; rgb_in = 3'b101; step();
        chk("R9 rgb oe on", rgb_oe, 1);
        chk("R9 rgb value", rgb_pin, 5);
        rgb_in = 3'b010; step();
        chk("R9 rgb value 2", rgb_pin, 2);
        osd_en = 1'b0; step();
        chk("R9 rgb oe off", rgb_oe, 0);
        chk("R9 rgb zero off", rgb_pin, 0);
    endtask

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_idle_before_sync();
        t_lines();
        t_realign();
        t_enable_switch();
        t_halftone();
        t_fast_blank();
        t_rgb();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule